// File: doc/BRIEF.md
# Road Ghost Removal Filter

This block thins the stream of candidate roads produced by pattern matching before those roads are sent on to track fitting. A road is a set of eight superstrip codes, one per detector layer, and any layer may be marked as holding no hit. Pattern banks that cover the same track with several slightly different patterns produce near-copies of one road. This filter removes them by comparing superstrips only, before any fit quality is known, so that fewer fits are needed downstream.

Within an event, each accepted road goes into a register store of up to sixteen entries. A new road is compared with every stored road in the same cycle. Two roads are ghosts of each other when they are identical, or when they disagree in exactly one layer and one of the two is empty in that layer. Of a ghost pair, the road with more filled layers stays. On a tie, the stored road stays. An end-of-event beat on the input drains the store in arrival order, then sends an end-of-event marker and clears the store. Input and output both use valid/ready streaming. While the output is busy, the input is held off.

The controller has four states. `ST_COLLECT` takes roads and compares them. `ST_BYPASS` presents one road that arrived while the store was full. `ST_DRAIN` walks the store. `ST_MARK` presents the end-of-event marker. The transitions are as follows:
- COLLECT goes to BYPASS when it accepts a road while the store is full.
- COLLECT goes to DRAIN when it accepts an end-of-event beat with a non-empty store, and to MARK when the store is empty.
- BYPASS goes back to COLLECT on an output handshake.
- DRAIN goes to MARK on the handshake of the last stored road.
- MARK goes to COLLECT on its handshake, and that handshake also clears the store.

Top module: `road_ghost_filter`

## Requirements
- R1: A road is 128 bits made of 8 fields of 16 bits. Layer k occupies bits [16k+15:16k]. Within a field, bit 15 set means the layer is empty, and bits 14:0 hold the superstrip code. Two fields match when both are empty, whatever their codes, or when both are filled with equal codes.
- R2: A new road that differs from every stored road in two or more layers, or in exactly one layer where both roads are filled, is appended to the store.
- R3: A new road that differs from a stored road in exactly one layer, where one of the two is empty, is a ghost of it. If the new road has more filled layers, it overwrites that stored entry in the same slot. Otherwise the new road is dropped.
- R4: A new road that matches a stored road in all eight layers is dropped.
- R5: An input beat with `in_eoe`=1 ends the event, and its road bits are ignored. The outputs are then the stored roads in slot order, each with `out_eoe`=0, followed by one marker beat with `out_eoe`=1 and `out_road` all zero.
- R6: After the marker handshake, the store is empty, so roads of the next event are not compared with roads of the previous event.
- R7: The store holds 16 roads. A road accepted while the store is full is neither compared nor stored. It appears on the output as a single beat with `out_eoe`=0 before the next input is taken. `out_overflow` rises with that road and stays high until the marker handshake.
- R8: `in_ready` is low whenever `out_valid` is high. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, `out_overflow` is 0, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_eoe | input | 1 | Input beat is an end-of-event marker |
| in_road | input | 128 | Candidate road, 8 fields of empty flag plus 15-bit code |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_eoe | output | 1 | Output beat is the end-of-event marker |
| out_road | output | 128 | Surviving road, or zero on the marker |
| out_overflow | output | 1 | A road bypassed the full store in this event |

## Verification
The assertions check the following on every cycle:
- input backpressure while an output beat is pending;
- stability of a stalled output beat;
- that an end-of-event beat starts the output phase;
- the zero road on the marker;
- that the store is empty after the marker handshake;
- that the store grows by at most one entry per road;
- that overflow is raised only when the store is full.

The comparison rule itself can only be shown by the bench's scenarios. These cover:
- which near-copies are dropped, replaced or kept;
- that codes in empty layers are ignored;
- slot-order draining;
- that no comparison is made across events;
- pass-through behaviour at full capacity.

// File: rtl/rgf_pkg.sv
package rgf_pkg;

    // Controller states of the ghost filter
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_BYPASS  = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_MARK    = 2'd3
    } rgf_state_e;

endpackage

// File: rtl/rgf_ghost_cmp.sv
// Compares one candidate road with one stored road.
module rgf_ghost_cmp #(
    parameter int LAYERS = 8,
    parameter int CODE_W = 15,
    localparam int FIELD_W = CODE_W + 1,
    localparam int ROAD_W  = LAYERS * FIELD_W,
    localparam int CNT_W   = $clog2(LAYERS + 1)
) (
    input  logic [ROAD_W-1:0] cand_road,
    input  logic [ROAD_W-1:0] kept_road,
    input  logic              kept_live,
    output logic              ghost,
    output logic              cand_wins
);

    logic [LAYERS-1:0] cand_empty;
    logic [LAYERS-1:0] kept_empty;
    logic [LAYERS-1:0] differs;
    logic [CNT_W-1:0]  n_diff;
    logic [CNT_W-1:0]  cand_fill;
    logic [CNT_W-1:0]  kept_fill;
    logic              single_empty_diff;

    for (genvar k = 0; k < LAYERS; k++) begin : g_layer
        assign cand_empty[k] = cand_road[k*FIELD_W + CODE_W];
        assign kept_empty[k] = kept_road[k*FIELD_W + CODE_W];
        // codes of empty layers never take part in the match (R1)
        assign differs[k] = (cand_empty[k] != kept_empty[k]) ||
                            (!cand_empty[k] &&
                             (cand_road[k*FIELD_W +: CODE_W] != kept_road[k*FIELD_W +: CODE_W]));
    end

    assign n_diff    = CNT_W'($countones(differs));
    assign cand_fill = CNT_W'($countones(~cand_empty));
    assign kept_fill = CNT_W'($countones(~kept_empty));

    assign single_empty_diff = (n_diff == CNT_W'(1)) &&
                               (|(differs & (cand_empty ^ kept_empty)));

    // identical roads or one-empty-layer neighbours are ghosts (R3, R4)
    assign ghost     = kept_live && ((n_diff == '0) || single_empty_diff);
    assign cand_wins = cand_fill > kept_fill;

endmodule

// File: rtl/rgf_road_store.sv
// Flip-flop store of accepted roads for the current event.
module rgf_road_store #(
    parameter int DEPTH  = 16,
    parameter int ROAD_W = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          append,
    input  logic                          replace,
    input  logic [IDX_W-1:0]              replace_idx,
    input  logic [ROAD_W-1:0]             wr_road,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [ROAD_W-1:0]             rd_road,
    output logic [DEPTH-1:0][ROAD_W-1:0]  slots,
    output logic [DEPTH-1:0]              live,
    output logic [CNT_W-1:0]              fill_count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_count <= '0;
        end else if (flush) begin
            fill_count <= '0;
        end else if (append) begin
            fill_count <= fill_count + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (append && (fill_count == CNT_W'(i))) begin
                slots[i] <= wr_road;
            end else if (replace && (replace_idx == IDX_W'(i))) begin
                slots[i] <= wr_road;
            end
        end
        assign live[i] = CNT_W'(i) < fill_count;
    end

    assign rd_road = slots[rd_idx];

endmodule

// File: rtl/rgf_ctrl.sv
// Event controller: collect, bypass on full, drain, end-of-event marker.
module rgf_ctrl
    import rgf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ROAD_W = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_eoe,
    input  logic [ROAD_W-1:0] in_road,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_eoe,
    output logic [ROAD_W-1:0] out_road,
    input  logic [CNT_W-1:0]  fill_count,
    input  logic              any_ghost,
    input  logic              cand_loses,
    input  logic [ROAD_W-1:0] rd_road,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              append,
    output logic              replace,
    output logic              flush,
    output logic              overflow
);

    rgf_state_e        state;
    rgf_state_e        state_nx;
    logic [IDX_W-1:0]  rd_q;
    logic [ROAD_W-1:0] byp_q;
    logic              ovf_q;
    logic              take_road;
    logic              take_eoe;
    logic              full;
    logic              last_slot;

    assign full      = fill_count == CNT_W'(DEPTH);
    assign take_road = in_valid && in_ready && !in_eoe;
    assign take_eoe  = in_valid && in_ready && in_eoe;
    assign last_slot = (CNT_W'(rd_q) + CNT_W'(1)) == fill_count;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: begin
                if (take_eoe) begin
                    state_nx = (fill_count == '0) ? ST_MARK : ST_DRAIN;
                end else if (take_road && full) begin
                    state_nx = ST_BYPASS;
                end
            end
            ST_BYPASS: if (out_ready) state_nx = ST_COLLECT;
            ST_DRAIN:  if (out_ready && last_slot) state_nx = ST_MARK;
            ST_MARK:   if (out_ready) state_nx = ST_COLLECT;
            default:   state_nx = ST_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_eoe   = 1'b0;
        out_road  = '0;
        append    = 1'b0;
        replace   = 1'b0;
        flush     = 1'b0;
        unique case (state)
            ST_COLLECT: begin
                in_ready = 1'b1;
                append   = take_road && !full && !any_ghost;
                replace  = take_road && !full && any_ghost && !cand_loses;
            end
            ST_BYPASS: begin
                out_valid = 1'b1;
                out_road  = byp_q;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_road  = rd_road;
            end
            ST_MARK: begin
                out_valid = 1'b1;
                out_eoe   = 1'b1;
                flush     = out_ready;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            byp_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case (state)
                ST_COLLECT: begin
                    if (take_road && full) begin
                        byp_q <= in_road;
                        ovf_q <= 1'b1;
                    end
                    if (take_eoe) rd_q <= '0;
                end
                ST_DRAIN: begin
                    if (out_ready && !last_slot) rd_q <= rd_q + IDX_W'(1);
                end
                ST_MARK: begin
                    if (out_ready) ovf_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign rd_idx   = rd_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/road_ghost_filter.sv
// Top: parallel ghost comparison against every stored road.
module road_ghost_filter #(
    parameter int LAYERS = 8,
    parameter int CODE_W = 15,
    parameter int DEPTH  = 16,
    localparam int ROAD_W = LAYERS * (CODE_W + 1),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eoe,
    input  logic [ROAD_W-1:0] in_road,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_eoe,
    output logic [ROAD_W-1:0] out_road,
    output logic              out_overflow
);

    logic [DEPTH-1:0][ROAD_W-1:0] slots;
    logic [DEPTH-1:0]             live;
    logic [DEPTH-1:0]             ghost_vec;
    logic [DEPTH-1:0]             wins_vec;
    logic [CNT_W-1:0]             fill_count;
    logic [IDX_W-1:0]             pick_idx;
    logic [IDX_W-1:0]             rd_idx;
    logic [ROAD_W-1:0]            rd_road;
    logic                         any_ghost;
    logic                         cand_loses;
    logic                         append;
    logic                         replace;
    logic                         flush;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        rgf_ghost_cmp #(
            .LAYERS (LAYERS),
            .CODE_W (CODE_W)
        ) u_cmp (
            .cand_road (in_road),
            .kept_road (slots[i]),
            .kept_live (live[i]),
            .ghost     (ghost_vec[i]),
            .cand_wins (wins_vec[i])
        );
    end

    // lowest-index ghost is the one a better candidate overwrites
    always_comb begin
        pick_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ghost_vec[i]) pick_idx = IDX_W'(i);
        end
    end

    assign any_ghost  = |ghost_vec;
    assign cand_loses = |(ghost_vec & ~wins_vec);

    rgf_road_store #(
        .DEPTH  (DEPTH),
        .ROAD_W (ROAD_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .append      (append),
        .replace     (replace),
        .replace_idx (pick_idx),
        .wr_road     (in_road),
        .rd_idx      (rd_idx),
        .rd_road     (rd_road),
        .slots       (slots),
        .live        (live),
        .fill_count  (fill_count)
    );

    rgf_ctrl #(
        .DEPTH  (DEPTH),
        .ROAD_W (ROAD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_eoe     (in_eoe),
        .in_road    (in_road),
        .in_ready   (in_ready),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_eoe    (out_eoe),
        .out_road   (out_road),
        .fill_count (fill_count),
        .any_ghost  (any_ghost),
        .cand_loses (cand_loses),
        .rd_road    (rd_road),
        .rd_idx     (rd_idx),
        .append     (append),
        .replace    (replace),
        .flush      (flush),
        .overflow   (out_overflow)
    );

endmodule

// File: rtl/rgf_checker.sv
module rgf_checker #(
    parameter int DEPTH  = 16,
    parameter int ROAD_W = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eoe,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_eoe,
    input logic [ROAD_W-1:0] out_road,
    input logic              out_overflow,
    input logic [CNT_W-1:0]  fill_count
);

    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_road) && $stable(out_eoe)));

    assert_eoe_starts_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eoe) |=> (out_valid && !in_ready));

    assert_marker_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eoe) |-> (out_road == '0));

    assert_clear_after_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eoe) |=> ((fill_count == '0) && !out_overflow));

    assert_grow_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_eoe) |=>
            ((fill_count == $past(fill_count)) || (fill_count == $past(fill_count) + CNT_W'(1))));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (fill_count == CNT_W'(DEPTH)));

endmodule

bind road_ghost_filter rgf_checker #(
    .DEPTH  (DEPTH),
    .ROAD_W (ROAD_W)
) u_rgf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_eoe       (in_eoe),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_eoe      (out_eoe),
    .out_road     (out_road),
    .out_overflow (out_overflow),
    .fill_count   (fill_count)
);

// File: tb/road_ghost_filter_test.sv
module road_ghost_filter_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_eoe = 1'b0;
    logic [127:0] in_road = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         out_eoe;
    logic [127:0] out_road;
    logic         out_overflow;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    road_ghost_filter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_eoe       (in_eoe),
        .in_road      (in_road),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_eoe      (out_eoe),
        .out_road     (out_road),
        .out_overflow (out_overflow)
    );

    // output capture
    logic [127:0] cap_road [64];
    logic         cap_eoe  [64];
    int           cap_n = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap_road[cap_n] = out_road;
            cap_eoe[cap_n]  = out_eoe;
            cap_n++;
        end
    end

    // Road builder. Layer k field = {empty flag, code}, with code = {seed, k, 4'h0}.
    // alt[3] flips the low code bit of layer alt[2:0].
    function automatic logic [127:0] mk_road(input logic [7:0] seed, input logic [7:0] emask,
                                             input logic [3:0] alt);
        logic [127:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            logic [14:0] c;
            c = {seed, 3'(k), 4'h0};
            if (alt[3] && int'(alt[2:0]) == k) c = c ^ 15'd1;
            r[k*16 +: 16] = {emask[k], c};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input int tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_beat(input logic [127:0] r, input logic e);
        @(negedge clk);
        in_valid = 1'b1;
        in_road  = r;
        in_eoe   = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eoe   = 1'b0;
    endtask

    task automatic wait_marker(input int base);
        @(negedge clk);
        #1;
        while (!(cap_n > base && cap_eoe[cap_n-1])) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Stimulus table. Action: 0 append at slot, 1 drop, 2 overwrite slot, 3 end of event.
    // Tags: R1 empty codes ignored, R2 append, R3 ghost rule, R4 exact copy, R5 order, R6 cleared store.
    localparam int NV = 13;
    localparam logic [7:0] T_SEED [NV] = '{8'd1, 8'd1, 8'd2, 8'd2, 8'd2, 8'd2, 8'd1, 8'd0,
                                           8'd3, 8'd3, 8'd1, 8'd0, 8'd0};
    localparam logic [7:0] T_MASK [NV] = '{8'h00, 8'h01, 8'h03, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00,
                                           8'h80, 8'h00, 8'h01, 8'h00, 8'h00};
    localparam logic [3:0] T_ALT  [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'hB, 4'h0,
                                           4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
    localparam int         T_ACT  [NV] = '{0, 1, 0, 2, 1, 0, 0, 3, 0, 2, 0, 3, 3};
    localparam int         T_SLOT [NV] = '{0, 0, 1, 1, 0, 2, 3, 0, 0, 0, 1, 0, 0};
    localparam int         T_TAG  [NV] = '{2, 3, 2, 3, 1, 2, 2, 4, 2, 3, 6, 5, 5};

    logic [127:0] exp_road [16];
    int           exp_tag  [16];
    int           exp_n = 0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int base;
        logic [127:0] r_x;
        logic [127:0] r_y;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(in_ready == 1'b1, 9, 128'(in_ready), 128'd1);
        check(out_valid == 1'b0, 9, 128'(out_valid), 128'd0);
        check(out_overflow == 1'b0, 9, 128'(out_overflow), 128'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            if (T_ACT[v] == 3) begin
                base = cap_n;
                send_beat(128'hFFFF, 1'b1);      // road bits on eoe ignored (R5)
                wait_marker(base);
                check(cap_n - base == exp_n + 1, T_TAG[v], 128'(cap_n - base), 128'(exp_n + 1));
                for (int i = 0; i < exp_n; i++) begin
                    check(cap_road[base+i] == exp_road[i] && !cap_eoe[base+i], exp_tag[i],
                          cap_road[base+i], exp_road[i]);
                end
                check(cap_road[cap_n-1] == '0, 5, cap_road[cap_n-1], 128'd0);
                exp_n = 0;
            end else begin
                r_x = mk_road(T_SEED[v], T_MASK[v], T_ALT[v]);
                send_beat(r_x, 1'b0);
                if (T_ACT[v] == 0) begin
                    exp_road[exp_n] = r_x;
                    exp_tag[exp_n]  = T_TAG[v];
                    exp_n++;
                end else if (T_ACT[v] == 2) begin
                    exp_road[T_SLOT[v]] = r_x;
                    exp_tag[T_SLOT[v]]  = T_TAG[v];
                end
            end
        end

        // R8 backpressure during drain
        r_x = mk_road(8'd60, 8'h00, 4'h0);
        r_y = mk_road(8'd61, 8'h10, 4'h0);
        @(posedge clk);
        #1 out_ready = 1'b0;
        send_beat(r_x, 1'b0);
        send_beat(r_y, 1'b0);
        base = cap_n;
        send_beat('0, 1'b1);
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b1 && in_ready == 1'b0, 8, {out_valid, in_ready}, 128'b10);
            check(out_road == r_x, 8, out_road, r_x);
        end
        @(posedge clk);
        #1 out_ready = 1'b1;
        wait_marker(base);
        check(cap_n - base == 3, 8, 128'(cap_n - base), 128'd3);
        check(cap_road[base] == r_x && cap_road[base+1] == r_y, 8, cap_road[base+1], r_y);

        // R7 full store: sixteen distinct roads, then pass-through
        for (int s = 0; s < 16; s++) send_beat(mk_road(8'(40 + s), 8'h00, 4'h0), 1'b0);
        base = cap_n;
        r_x = mk_road(8'd40, 8'h01, 4'h0);       // would be a dropped ghost if compared
        send_beat(r_x, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        check(cap_n - base == 1, 7, 128'(cap_n - base), 128'd1);
        check(cap_road[base] == r_x && !cap_eoe[base], 7, cap_road[base], r_x);
        check(out_overflow == 1'b1, 7, 128'(out_overflow), 128'd1);
        r_y = mk_road(8'd40, 8'h00, 4'h0);       // exact copy of slot 0, still passes
        send_beat(r_y, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        check(cap_n - base == 2 && cap_road[base+1] == r_y, 7, cap_road[base+1], r_y);
        base = cap_n;
        send_beat('0, 1'b1);
        wait_marker(base);
        check(cap_n - base == 17, 7, 128'(cap_n - base), 128'd17);
        for (int s = 0; s < 16; s++) begin
            check(cap_road[base+s] == mk_road(8'(40 + s), 8'h00, 4'h0), 5,
                  cap_road[base+s], mk_road(8'(40 + s), 8'h00, 4'h0));
        end
        @(negedge clk);
        check(out_overflow == 1'b0, 7, 128'(out_overflow), 128'd0);
        check(in_ready == 1'b1, 6, 128'(in_ready), 128'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule